// File: doc/BRIEF.md
# Serial Debug Command Register

This block holds the command byte of a single-wire background debug link. A pin decoder upstream turns the host's pulses into a stream of bits. Each bit arrives with a one-cycle valid strobe. A separate one-cycle pulse marks each falling edge the host drives. The block shifts eight bits into a byte, with the most significant bit first, and loads the byte into the command register. A status flag is raised for exactly one cycle when a serial load happens. The six upper bits of the command are decoded and brought out on their own pins.

The serial bit input is a stream with no back-pressure. Every cycle in which `ser_valid` is high delivers one bit, and the block always takes it, so there is no ready signal. A host that falls silent for too long loses what it had sent: an idle timer clears the command and throws away any half-shifted byte. In a special test mode, a parallel port can write the command byte directly. The block also holds the debug clock-select setting, which is 0 for the dedicated debug clock and 1 for the bus clock. A change to this setting is held pending. It takes effect only when a new command starts after a guard interval has run out. A bus clock slower than the debug clock always forces bus-clock operation.

Top module: `dbg_cmd_reg`

## Requirements
- R1: While `rst_n` is low, `cmd_out` is 0, `sdv` is 0 and `clk_sel` is 0. The idle timer counts from the release of reset.
- R2: Serial bits are taken MSB first. On the clock edge that samples the 8th strobed bit, `cmd_out` becomes the assembled byte. The first bit received is bit 7.
- R3: `sdv` is 1 for exactly the one cycle after a serial load and 0 otherwise. A serial byte that loses to a parallel write does not raise it.
- R4: When `par_we` is high, `cmd_out` takes `par_data` on that edge. If a serial byte completes on the same edge, the parallel write wins and the serial byte is discarded.
- R5: Suppose the last `host_fall` was sampled on edge e0. Then, if no further `host_fall` arrives, `cmd_out` is cleared on edge e0+IDLE_LIMIT, and any partially shifted bits are discarded. After that the timer saturates, so the clear happens only once per idle period.
- R6: Each `host_fall` pulse restarts the idle period from zero.
- R7: Suppose a `clk_sel_req` pulse with value `clk_sel_val` is sampled on edge e. That value moves into `clk_sel` on the edge that samples the first bit of a command. This happens only if that edge is e+GUARD_CYCLES+1 or later. Earlier command starts leave `clk_sel` unchanged. A newer request replaces a pending one and restarts the guard.
- R8: `use_bus_clk` equals `clk_sel` OR `bus_slow`, with no register in between.
- R9: The decoded flags come from fixed bit positions of `cmd_out`: `f_hw` from bit 7, `f_data` from bit 6, `f_read` from bit 5, `f_bgnd` from bit 4, `f_word` from bit 3 and `f_dbg` from bit 2.
- R10: A parallel write on the same edge as an idle timeout wins: `cmd_out` takes `par_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | debug clock |
| rst_n | input | 1 | asynchronous reset, active low |
| ser_valid | input | 1 | bit strobe from the pin decoder |
| ser_bit | input | 1 | serial data bit |
| host_fall | input | 1 | pulse for each host falling edge |
| par_we | input | 1 | parallel write enable (test mode) |
| par_data | input | CMD_W | parallel write data |
| clk_sel_req | input | 1 | end of data phase of a clock-select write |
| clk_sel_val | input | 1 | requested clock-select value |
| bus_slow | input | 1 | bus clock is slower than debug clock |
| cmd_out | output | CMD_W | command register |
| sdv | output | 1 | shift-data-valid flag |
| clk_sel | output | 1 | committed clock-select setting |
| use_bus_clk | output | 1 | effective choice: bus clock |
| f_hw | output | 1 | hardware/firmware flag |
| f_data | output | 1 | data-phase flag |
| f_read | output | 1 | read/write flag |
| f_bgnd | output | 1 | background-entry flag |
| f_word | output | 1 | word/byte flag |
| f_dbg | output | 1 | debug/user space flag |

## Verification
Two pairs of events can land on the same clock edge and must be resolved. The first pair is a parallel write meeting the completion of a serial byte. The bench shifts seven bits and then drives the eighth bit in the same cycle as a parallel write, and checks that the parallel data is loaded with no `sdv`. The second pair is a parallel write meeting the idle timeout. The bench counts exactly IDLE_LIMIT cycles from the last host edge and writes in that cycle, and the parallel data must survive. A behavioural reference model, updated on every edge, is compared with all outputs in every cycle.

// File: rtl/dbg_cmd_pkg.sv
package dbg_cmd_pkg;

  // source chosen for the command register on a given edge
  typedef enum logic [1:0] {
    SRC_HOLD = 2'd0,
    SRC_PAR  = 2'd1,
    SRC_CLR  = 2'd2,
    SRC_SER  = 2'd3
  } cmd_src_e;

  // bit positions of the decoded flags, counted down from the MSB
  localparam int FLAG_HW_OFS   = 0;
  localparam int FLAG_DATA_OFS = 1;
  localparam int FLAG_RD_OFS   = 2;
  localparam int FLAG_BG_OFS   = 3;
  localparam int FLAG_WORD_OFS = 4;
  localparam int FLAG_DBG_OFS  = 5;

endpackage

// File: rtl/dbg_shift_in.sv
module dbg_shift_in #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bit_valid,
  input  logic         bit_in,
  input  logic         flush,
  output logic         cmd_start,
  output logic         byte_done,
  output logic [W-1:0] byte_out
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [CW-1:0] cnt;
  logic [W-1:0]  sh;

  assign cmd_start = bit_valid && (cnt == '0);
  assign byte_done = bit_valid && !flush && (cnt == LAST);
  assign byte_out  = {sh[W-2:0], bit_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      sh  <= '0;
    end else if (flush) begin
      cnt <= '0;
      sh  <= '0;
    end else if (bit_valid) begin
      sh  <= byte_out;
      cnt <= (cnt == LAST) ? '0 : cnt + CW'(1);
    end
  end

  // R2
  byte_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> (cnt == '0));

  // R5
  flush_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (cnt == '0));

endmodule

// File: rtl/dbg_idle_timer.sv
module dbg_idle_timer #(
  parameter int LIMIT = 512
) (
  input  logic clk,
  input  logic rst_n,
  input  logic host_fall,
  output logic timeout
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] SAT  = CW'(LIMIT);
  localparam logic [CW-1:0] FIRE = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  assign timeout = !host_fall && (cnt == FIRE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (host_fall)    cnt <= '0;
    else if (cnt != SAT)   cnt <= cnt + CW'(1);
  end

  // R5
  idle_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == SAT && !host_fall) |=> (cnt == SAT));

  // R5
  single_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |=> !timeout);

  // R6
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_fall |=> (cnt == '0));

endmodule

// File: rtl/dbg_clk_select.sv
module dbg_clk_select #(
  parameter int GUARD = 150
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic req_val,
  input  logic cmd_start,
  input  logic bus_slow,
  output logic sel,
  output logic use_bus
);
  localparam int GW = $clog2(GUARD + 1);
  localparam logic [GW-1:0] GLOAD = GW'(GUARD);

  logic          pend;
  logic          pval;
  logic [GW-1:0] guard;
  logic          commit;

  assign commit  = pend && !req && cmd_start && (guard == '0);
  assign use_bus = sel | bus_slow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend  <= 1'b0;
      pval  <= 1'b0;
      guard <= '0;
      sel   <= 1'b0;
    end else if (req) begin
      pend  <= 1'b1;
      pval  <= req_val;
      guard <= GLOAD;
    end else begin
      if (guard != '0) guard <= guard - GW'(1);
      if (commit) begin
        sel  <= pval;
        pend <= 1'b0;
      end
    end
  end

  // R7
  sel_at_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel != $past(sel)) |-> $past(cmd_start));

  // R7
  req_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> pend);

endmodule

// File: rtl/dbg_cmd_reg.sv
module dbg_cmd_reg #(
  parameter int CMD_W        = 8,
  parameter int IDLE_LIMIT   = 512,
  parameter int GUARD_CYCLES = 150
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_valid,
  input  logic             ser_bit,
  input  logic             host_fall,
  input  logic             par_we,
  input  logic [CMD_W-1:0] par_data,
  input  logic             clk_sel_req,
  input  logic             clk_sel_val,
  input  logic             bus_slow,
  output logic [CMD_W-1:0] cmd_out,
  output logic             sdv,
  output logic             clk_sel,
  output logic             use_bus_clk,
  output logic             f_hw,
  output logic             f_data,
  output logic             f_read,
  output logic             f_bgnd,
  output logic             f_word,
  output logic             f_dbg
);
  import dbg_cmd_pkg::*;

  localparam int TOP = CMD_W - 1;

  logic             cmd_start;
  logic             byte_done;
  logic [CMD_W-1:0] byte_val;
  logic             idle_clr;
  cmd_src_e         src;

  dbg_shift_in #(.W(CMD_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_valid (ser_valid),
    .bit_in    (ser_bit),
    .flush     (idle_clr),
    .cmd_start (cmd_start),
    .byte_done (byte_done),
    .byte_out  (byte_val)
  );

  dbg_idle_timer #(.LIMIT(IDLE_LIMIT)) u_idle (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_fall (host_fall),
    .timeout   (idle_clr)
  );

  dbg_clk_select #(.GUARD(GUARD_CYCLES)) u_csel (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (clk_sel_req),
    .req_val   (clk_sel_val),
    .cmd_start (cmd_start),
    .bus_slow  (bus_slow),
    .sel       (clk_sel),
    .use_bus   (use_bus_clk)
  );

  // priority: parallel write, then idle clear, then serial load
  always_comb begin
    if (par_we)         src = SRC_PAR;
    else if (idle_clr)  src = SRC_CLR;
    else if (byte_done) src = SRC_SER;
    else                src = SRC_HOLD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_out <= '0;
      sdv     <= 1'b0;
    end else begin
      sdv <= (src == SRC_SER);
      unique case (src)
        SRC_PAR:  cmd_out <= par_data;
        SRC_CLR:  cmd_out <= '0;
        SRC_SER:  cmd_out <= byte_val;
        default:  cmd_out <= cmd_out;
      endcase
    end
  end

  assign f_hw   = cmd_out[TOP - FLAG_HW_OFS];
  assign f_data = cmd_out[TOP - FLAG_DATA_OFS];
  assign f_read = cmd_out[TOP - FLAG_RD_OFS];
  assign f_bgnd = cmd_out[TOP - FLAG_BG_OFS];
  assign f_word = cmd_out[TOP - FLAG_WORD_OFS];
  assign f_dbg  = cmd_out[TOP - FLAG_DBG_OFS];

  // R4
  par_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    par_we |=> (cmd_out == $past(par_data)));

  // R4
  par_no_sdv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    par_we |=> !sdv);

  // R3
  sdv_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sdv |=> !sdv);

  // R5
  idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_clr && !par_we) |=> (cmd_out == '0));

endmodule

// File: tb/dbg_cmd_reg_test.sv
module dbg_cmd_reg_test;
  localparam int CLK_PERIOD = 10;
  localparam int LIMIT = 512;
  localparam int GUARD = 150;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_valid = 0, ser_bit = 0, host_fall = 0, par_we = 0;
  logic [7:0] par_data = '0;
  logic clk_sel_req = 0, clk_sel_val = 0, bus_slow = 0;
  logic [7:0] cmd_out;
  logic sdv, clk_sel, use_bus_clk, f_hw, f_data, f_read, f_bgnd, f_word, f_dbg;

  int total = 0;
  int bad = 0;
  bit cmp_on = 0;

  // reference model state
  int m_cnt, m_sh, m_idle, m_cmd, m_sdv, m_sel, m_pend, m_pval, m_req_cyc, m_cyc;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_cmd_reg #(.CMD_W(8), .IDLE_LIMIT(LIMIT), .GUARD_CYCLES(GUARD)) uut (
    .clk(clk), .rst_n(rst_n), .ser_valid(ser_valid), .ser_bit(ser_bit),
    .host_fall(host_fall), .par_we(par_we), .par_data(par_data),
    .clk_sel_req(clk_sel_req), .clk_sel_val(clk_sel_val), .bus_slow(bus_slow),
    .cmd_out(cmd_out), .sdv(sdv), .clk_sel(clk_sel), .use_bus_clk(use_bus_clk),
    .f_hw(f_hw), .f_data(f_data), .f_read(f_read), .f_bgnd(f_bgnd),
    .f_word(f_word), .f_dbg(f_dbg)
  );

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_sh = 0; m_idle = 0; m_cmd = 0; m_sdv = 0;
      m_sel = 0; m_pend = 0; m_pval = 0; m_req_cyc = 0; m_cyc = 0;
    end else begin
      bit tmo, start, load;
      m_cyc++;
      tmo   = (m_idle == LIMIT - 1) && !host_fall;
      start = ser_valid && (m_cnt == 0);
      load  = 0;
      if (tmo) begin
        m_cnt = 0; m_sh = 0;
      end else if (ser_valid) begin
        m_sh = ((m_sh << 1) | int'(ser_bit)) & 255;
        if (m_cnt == 7) begin load = 1; m_cnt = 0; end
        else m_cnt++;
      end
      m_sdv = (load && !par_we) ? 1 : 0;
      if (par_we) m_cmd = int'(par_data);
      else if (tmo) m_cmd = 0;
      else if (load) m_cmd = m_sh;
      if (host_fall) m_idle = 0;
      else if (m_idle < LIMIT) m_idle++;
      if (clk_sel_req) begin
        m_pend = 1; m_pval = int'(clk_sel_val); m_req_cyc = m_cyc;
      end else if (m_pend && start && (m_cyc - m_req_cyc > GUARD)) begin
        m_sel = m_pval; m_pend = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_on && rst_n) begin
      chk("R2", int'(cmd_out), m_cmd);
      chk("R3", int'(sdv), m_sdv);
      chk("R7", int'(clk_sel), m_sel);
      chk("R8", int'(use_bus_clk), m_sel | int'(bus_slow));
      chk("R9", int'({f_hw, f_data, f_read, f_bgnd, f_word, f_dbg}), m_cmd >> 2);
    end
  end

  task automatic step(bit bv, bit b, bit hf, bit pw, logic [7:0] pd, bit rq, bit rv);
    ser_valid = bv; ser_bit = b; host_fall = hf; par_we = pw; par_data = pd;
    clk_sel_req = rq; clk_sel_val = rv;
    @(posedge clk); #1;
    ser_valid = 0; ser_bit = 0; host_fall = 0; par_we = 0; par_data = '0;
    clk_sel_req = 0; clk_sel_val = 0;
  endtask

  task automatic send_byte(logic [7:0] b);
    for (int i = 7; i >= 0; i--) step(1, b[i], 1, 0, 8'h00, 0, 0);
  endtask

  task automatic idle(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    total++; bad++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1", int'(cmd_out), 0);
    chk("R1", int'(sdv), 0);
    chk("R1", int'(clk_sel), 0);
    rst_n = 1; cmp_on = 1;
    idle(2);

    // R2 MSB-first assembly, R3 one-cycle valid
    send_byte(8'hA5);
    chk("R2", int'(cmd_out), 'hA5);
    chk("R3", int'(sdv), 1);
    idle(1);
    chk("R3", int'(sdv), 0);
    send_byte(8'h3C);
    chk("R2", int'(cmd_out), 'h3C);

    // R4 parallel write alone, then colliding with serial completion
    step(0, 0, 0, 1, 8'h5A, 0, 0);
    chk("R4", int'(cmd_out), 'h5A);
    for (int i = 7; i >= 1; i--) step(1, 1'b1, 1, 0, 8'h00, 0, 0);
    step(1, 1, 1, 1, 8'h81, 0, 0);
    chk("R4", int'(cmd_out), 'h81);
    chk("R4", int'(sdv), 0);

    // R5 exact timeout edge
    step(0, 0, 1, 0, 8'h00, 0, 0);
    idle(LIMIT - 1);
    chk("R5", int'(cmd_out), 'h81);
    idle(1);
    chk("R5", int'(cmd_out), 0);

    // R5 saturation: no second clear in the same idle period
    step(0, 0, 0, 1, 8'h66, 0, 0);
    idle(LIMIT + 20);
    chk("R5", int'(cmd_out), 'h66);

    // R6 host edges keep restarting the idle period
    step(0, 0, 1, 0, 8'h00, 0, 0);
    idle(LIMIT - 2);
    step(0, 0, 1, 0, 8'h00, 0, 0);
    idle(LIMIT - 2);
    chk("R6", int'(cmd_out), 'h66);

    // R5 partial shift discarded by timeout
    for (int i = 0; i < 3; i++) step(1, 1'b1, 1, 0, 8'h00, 0, 0);
    idle(LIMIT + 5);
    send_byte(8'hC3);
    chk("R5", int'(cmd_out), 'hC3);

    // R10 parallel write on the timeout edge
    step(0, 0, 1, 0, 8'h00, 0, 0);
    idle(LIMIT - 1);
    step(0, 0, 0, 1, 8'h77, 0, 0);
    chk("R10", int'(cmd_out), 'h77);

    // R7 request, early command start does not commit
    step(0, 0, 1, 0, 8'h00, 1, 1);
    idle(10);
    send_byte(8'h11);
    chk("R7", int'(clk_sel), 0);
    idle(GUARD);
    send_byte(8'h22);
    chk("R7", int'(clk_sel), 1);

    // R7 boundary: start exactly GUARD edges after request is too early
    step(0, 0, 1, 0, 8'h00, 1, 0);
    idle(GUARD - 1);
    send_byte(8'h44);
    chk("R7", int'(clk_sel), 1);
    send_byte(8'h45);
    chk("R7", int'(clk_sel), 0);

    // R8 slow bus clock forces bus-clock operation
    bus_slow = 1; #1;
    chk("R8", int'(use_bus_clk), 1);
    idle(2);
    bus_slow = 0; #1;
    chk("R8", int'(use_bus_clk), 0);

    // R9 flag positions
    step(0, 0, 1, 1, 8'hFC, 0, 0);
    chk("R9", int'({f_hw, f_data, f_read, f_bgnd, f_word, f_dbg}), 'h3F);
    step(0, 0, 1, 1, 8'h84, 0, 0);
    chk("R9", int'({f_hw, f_data, f_read, f_bgnd, f_word, f_dbg}), 'h21);

    idle(3);
    finish_run();
  end

endmodule